// File: doc/BRIEF.md
# Two-Way Host Port With Word Staging

This block joins a 16-bit processor to an 8-bit external host. Each direction holds a word in two stages. Outbound, the processor places a 16-bit word in a staging register. The block then moves that word into a byte pair that the host reads one byte at a time. Inbound, the host writes two bytes into a staging pair. The block then moves them as one word into a receive register that the processor reads.

Each direction moves its word by itself, one clock after it can. A word moves only when the staging side holds data and the destination side is empty. The empty and full flags are set and cleared by particular accesses, and which byte the host touches matters. A processor interrupt and a host request line are driven from these flags, each under its own enable input.

Top module: `host_port_bridge`

## Requirements
- R1: After reset, p_txe and h_txe are 1 and h_rxf and p_rxf are 0. With all enables low, p_tx_irq, p_rx_irq and h_req are 0.
- R2: A processor write (p_wr_tx) clears p_txe on the next clock. Once p_txe is 0 and h_rxf is 0, the staged word moves into the host byte pair on the next clock, and both h_rxf and p_txe become 1.
- R3: While h_rxf is 1, no outbound move happens. The staged word waits with p_txe at 0, and the host bytes keep their value.
- R4: A host read at address 6 returns the high byte and at address 7 the low byte. A read at address 6 leaves h_rxf at 1. A read at address 7 clears h_rxf on the next clock.
- R5: A host write at address 6 loads the high byte and at address 7 the low byte. A write at address 7 clears h_txe on the next clock. Once h_txe is 0 and p_rxf is 0, the word {high, low} moves into p_rdata on the next clock, and both p_rxf and h_txe become 1.
- R6: While p_rxf is 1, no inbound move happens and p_rdata holds. A processor read (p_rd_rx) clears p_rxf on the next clock.
- R7: p_tx_irq equals p_txie AND p_txe. p_rx_irq equals p_rxie AND p_rxf.
- R8: h_req equals (h_rreq_en AND h_rxf) OR (h_treq_en AND h_txe).
- R9: A host read at any address other than 6 and 7 returns 0. A host write to such an address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_wr_tx | input | 1 | Processor write strobe for the outbound word |
| p_wdata | input | 16 | Outbound word |
| p_rd_rx | input | 1 | Processor read strobe for the inbound word |
| p_rdata | output | 16 | Inbound word |
| p_txie | input | 1 | Processor transmit interrupt enable |
| p_rxie | input | 1 | Processor receive interrupt enable |
| p_txe | output | 1 | Outbound staging register empty |
| p_rxf | output | 1 | Inbound word register full |
| p_tx_irq | output | 1 | Transmit interrupt |
| p_rx_irq | output | 1 | Receive interrupt |
| h_addr | input | 3 | Host byte address |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_rreq_en | input | 1 | Host request enable for receive-full |
| h_treq_en | input | 1 | Host request enable for transmit-empty |
| h_rxf | output | 1 | Host byte pair full |
| h_txe | output | 1 | Host transmit byte pair empty |
| h_req | output | 1 | Host request |

## Verification
A wrong flag shows up within one or two clocks. It appears as a missing or extra request or interrupt, or as a word that moves when it should wait. A move fired too early overwrites the bytes the host has not yet read. A move that never fires leaves the empty flag stuck at 0. The bench therefore reads back every word in both byte orders. It also holds each destination full while a second word waits, which exposes any word lost or duplicated by the gating.

// File: rtl/host_port_bridge.sv
module host_port_bridge #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] ADR_HI = 3'd6,
  parameter logic [ADDR_W-1:0] ADR_LO = 3'd7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                p_wr_tx,
  input  logic [WORD_W-1:0]   p_wdata,
  input  logic                p_rd_rx,
  output logic [WORD_W-1:0]   p_rdata,
  input  logic                p_txie,
  input  logic                p_rxie,
  output logic                p_txe,
  output logic                p_rxf,
  output logic                p_tx_irq,
  output logic                p_rx_irq,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic                h_rd,
  input  logic                h_wr,
  input  logic [WORD_W/2-1:0] h_wdata,
  output logic [WORD_W/2-1:0] h_rdata,
  input  logic                h_rreq_en,
  input  logic                h_treq_en,
  output logic                h_rxf,
  output logic                h_txe,
  output logic                h_req
);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] out_stage, out_pair, in_word;
  logic [BYTE_W-1:0] in_hi, in_lo;
  logic out_move, in_move, rd_lo, wr_hi, wr_lo;

  assign out_move = !p_txe && !h_rxf;
  assign in_move  = !h_txe && !p_rxf;
  assign rd_lo    = h_rd && h_addr == ADR_LO;
  assign wr_hi    = h_wr && h_addr == ADR_HI;
  assign wr_lo    = h_wr && h_addr == ADR_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_stage <= '0;
      out_pair  <= '0;
      p_txe     <= 1'b1;
      h_rxf     <= 1'b0;
    end else begin
      if (out_move) begin
        out_pair <= out_stage;
        p_txe    <= 1'b1;
      end
      if (p_wr_tx) begin
        out_stage <= p_wdata;
        p_txe     <= 1'b0;
      end
      if (rd_lo) h_rxf <= 1'b0;
      if (out_move) h_rxf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_hi   <= '0;
      in_lo   <= '0;
      in_word <= '0;
      h_txe   <= 1'b1;
      p_rxf   <= 1'b0;
    end else begin
      if (in_move) begin
        in_word <= {in_hi, in_lo};
        h_txe   <= 1'b1;
      end
      if (wr_hi) in_hi <= h_wdata;
      if (wr_lo) begin
        in_lo <= h_wdata;
        h_txe <= 1'b0;
      end
      if (p_rd_rx) p_rxf <= 1'b0;
      if (in_move) p_rxf <= 1'b1;
    end
  end

  assign p_rdata  = in_word;
  assign p_tx_irq = p_txie & p_txe;
  assign p_rx_irq = p_rxie & p_rxf;
  assign h_req    = (h_rreq_en & h_rxf) | (h_treq_en & h_txe);

  always_comb begin
    h_rdata = '0;
    if (h_rd && h_addr == ADR_HI) h_rdata = out_pair[WORD_W-1:BYTE_W];
    else if (rd_lo)               h_rdata = out_pair[BYTE_W-1:0];
  end

  p_wr_clears_txe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_wr_tx |=> !p_txe);
  p_out_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!p_txe && !h_rxf && !p_wr_tx) |=> (h_rxf && p_txe));
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rxf && !rd_lo) |=> (h_rxf && $stable(out_pair)));
  p_lo_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rxf && rd_lo) |=> !h_rxf);
  p_hi_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rxf && h_rd && h_addr == ADR_HI) |=> h_rxf);
  p_lo_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> !h_txe);
  p_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rxf && !p_rd_rx) |=> (p_rxf && $stable(p_rdata)));
  p_rd_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rxf && p_rd_rx) |=> !p_rxf);
endmodule

// File: tb/sim_host_port_bridge.sv
module sim_host_port_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic p_wr_tx = 0, p_rd_rx = 0, p_txie = 0, p_rxie = 0;
  logic [15:0] p_wdata = '0, p_rdata;
  logic p_txe, p_rxf, p_tx_irq, p_rx_irq;
  logic [2:0] h_addr = '0;
  logic h_rd = 0, h_wr = 0, h_rreq_en = 0, h_treq_en = 0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic h_rxf, h_txe, h_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_port_bridge u0 (.*);

  localparam logic [31:0] VEC [8] = '{
    32'h1234_ABCD, 32'h0000_FFFF, 32'hFFFF_0000, 32'hA5A5_5A5A,
    32'h00FF_FF00, 32'h8001_0180, 32'h7E7E_E7E7, 32'hC0DE_BEEF};

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic pwrite(logic [15:0] w);
    p_wdata = w; p_wr_tx = 1; cyc(); p_wr_tx = 0;
  endtask

  task automatic prd(output logic [15:0] w);
    #1 w = p_rdata; p_rd_rx = 1; cyc(); p_rd_rx = 0;
  endtask

  task automatic hread(logic [2:0] a, output logic [7:0] b);
    h_addr = a; h_rd = 1; #1 b = h_rdata; cyc(); h_rd = 0;
  endtask

  task automatic hwrite(logic [2:0] a, logic [7:0] b);
    h_addr = a; h_wdata = b; h_wr = 1; cyc(); h_wr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] w;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 p_txe", p_txe, 1); chk("R1 h_txe", h_txe, 1);
    chk("R1 h_rxf", h_rxf, 0); chk("R1 p_rxf", p_rxf, 0);
    chk("R1 outs", {p_tx_irq, p_rx_irq, h_req}, 0);

    foreach (VEC[i]) begin
      logic [15:0] o, n;
      o = VEC[i][31:16]; n = VEC[i][15:0];
      pwrite(o);
      chk("R2 txe cleared", p_txe, 0);
      cyc();
      chk("R2 moved", {h_rxf, p_txe}, 2'b11);
      hread(6, b); chk("R4 high byte", b, o[15:8]);
      chk("R4 hi keeps rxf", h_rxf, 1);
      hread(7, b); chk("R4 low byte", b, o[7:0]);
      chk("R4 lo clears rxf", h_rxf, 0);
      hwrite(6, n[15:8]); hwrite(7, n[7:0]);
      chk("R5 h_txe cleared", h_txe, 0);
      cyc();
      chk("R5 moved", {p_rxf, h_txe}, 2'b11);
      prd(w); chk("R5 word", w, n);
      chk("R6 rd clears", p_rxf, 0);
    end

    // R3 second word waits while host bytes full
    pwrite(16'h1111); cyc(); pwrite(16'h2222); cyc(); cyc();
    chk("R3 pending", p_txe, 0);
    hread(6, b); chk("R3 held hi", b, 8'h11);
    hread(7, b); chk("R3 held lo", b, 8'h11);
    cyc();
    chk("R3 second moved", {h_rxf, p_txe}, 2'b11);
    hread(7, b); chk("R3 second lo", b, 8'h22);

    // R6 inbound waits while processor full
    hwrite(6, 8'h33); hwrite(7, 8'h44); cyc();
    hwrite(6, 8'h55); hwrite(7, 8'h66); cyc(); cyc();
    chk("R6 pending", h_txe, 0);
    chk("R6 held", p_rdata, 16'h3344);
    prd(w); cyc();
    chk("R6 second", p_rdata, 16'h5566);
    chk("R6 full again", p_rxf, 1);
    prd(w);

    // R7 interrupts
    p_txie = 1; #1 chk("R7 tx irq on", p_tx_irq, 1);
    pwrite(16'h0F0F); #1 chk("R7 tx irq off", p_tx_irq, 0);
    p_rxie = 1; #1 chk("R7 rx irq off", p_rx_irq, 0);
    hwrite(6, 8'h01); hwrite(7, 8'h02); cyc();
    chk("R7 rx irq on", p_rx_irq, 1);
    prd(w); p_txie = 0; p_rxie = 0;
    cyc();

    // R8 host request; host bytes now full with 0F0F
    h_rreq_en = 1; #1 chk("R8 rreq", h_req, 1);
    h_rreq_en = 0; #1 chk("R8 none", h_req, 0);
    h_treq_en = 1; #1 chk("R8 treq", h_req, 1);
    hwrite(6, 8'h09); hwrite(7, 8'h0A);
    chk("R8 treq drop", h_req, 0);
    cyc(); prd(w); h_treq_en = 0;

    // R9 unmapped accesses
    hread(0, b); chk("R9 read addr0", b, 0);
    hread(5, b); chk("R9 read addr5", b, 0);
    chk("R9 read keeps rxf", h_rxf, 1);
    hwrite(3, 8'hEE); cyc();
    chk("R9 write ignored", {h_txe, p_rxf}, 2'b10);
    hread(7, b); chk("R9 low intact", b, 8'h0F);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule